// File: doc/BRIEF.md
# Two-tier maskable interrupt controller

This block gathers interrupt events for a small 8-bit microcontroller core and decides when the CPU must divert to its service routine. Five sources are latched into flag bits. Three are core sources: an external pin with a selectable edge, a timer overflow pulse and a detector that watches the upper port pins for change. Two are peripheral sources: a comparator event and an optional parallel-port event. A flag only raises a request when its own enable bit is set. Peripheral flags also need a peripheral-enable bit. Every request then passes a global enable.

The CPU sees a registered request line. When the CPU accepts a request with a one-cycle acknowledge, the block clears the global enable, pulses a vector-load strobe and presents the service address 0x0004. A return pulse sets the global enable again. A software write that clears the global enable while a request is due suppresses that request and flags a NOP slot instead, and the flag stays pending. While the core sleeps, any enabled request drives a wake line, whatever the state of the global enable. Software reads and writes the registers through a simple bus. Read data is registered and appears one cycle after the read strobe.

Top module: `intc_core`

## Requirements
- R1: After reset all flags, all enables and the global enable (CTL bit 7) read as 0, the edge select (CFG bit 0) reads 1, and irq_req, nop_slot, vec_load and wake are 0.
- R2: A flag sets on its event whether or not its enable or the global enable is set. CTL bit 0 is the external-pin flag, bit 1 is the timer flag and bit 2 is the port-change flag. PFLG bit 0 is the comparator flag and bit 1 is the parallel-port flag. The external pin passes two synchronising flops and is detected on a rising edge when CFG bit 0 is 1, or on a falling edge when it is 0. A pin change is visible in the flag after 3 clock edges, and in irq_req after 4 clock edges.
- R3: The port-change flag sets while the synchronised upper port pins differ from the snapshot taken at the last read of PORT (address 3). Reading PORT returns the pins in bits 3:0 and refreshes the snapshot.
- R4: Flags clear only through software writes (CTL address 0, PFLG address 1). A hardware event in the same cycle as a clearing write still leaves its flag set.
- R5: irq_req rises one cycle after the global enable is 1 and at least one of these holds: a core flag with its enable set (CTL bits 3, 4 and 5 enable flags 0, 1 and 2), or a peripheral flag whose PEN bit (address 2, bit 0 comparator, bit 1 parallel port) is set while the peripheral enable (CTL bit 6) is 1.
- R6: When irq_req and irq_ack are both high, the next cycle shows vec_load high with vec_addr 0x0004 and irq_req low, and the global enable reads 0.
- R7: A ret_fie pulse sets the global enable. A flag still pending then raises irq_req again one cycle later. If ret_fie and irq_ack come together, the acknowledge wins.
- R8: A CTL write that clears the global enable while a request is due gives nop_slot high and irq_req low in the next cycle. The flag stays set.
- R9: wake is high one cycle after sleep_mode is high and any request is enabled as in R5, ignoring the global enable.
- R10: Reading any register returns its contents on bus_rdata one cycle after bus_rd. CFG is at address 4. Unused bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_pins | input | PORT_W | Upper port pins watched for change |
| cmp_evt | input | 1 | Comparator event pulse |
| pp_evt | input | 1 | Parallel-port event pulse |
| sleep_mode | input | 1 | Core is sleeping |
| irq_ack | input | 1 | CPU accepts the pending request |
| ret_fie | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| nop_slot | output | 1 | Suppressed dispatch, CPU inserts a NOP |
| vec_load | output | 1 | Load vec_addr into the program counter |
| vec_addr | output | PC_W | Service vector address |
| wake | output | 1 | Wake-up request while sleeping |

## Verification
The hardest case to reach is the suppressed dispatch. A request has to be fully armed, with a flag, its enables and the global enable set, at the very moment software clears the global enable. The stimulus gets there in three steps. It arms a comparator request while the peripheral enable is still off, so the request is held back. It then sets the peripheral enable together with the global enable. Once the request line is high, it writes the control register with bit 7 cleared. A behavioural model then checks nop_slot, the request line and the surviving flag on every clock. It also checks a clearing write that lands in the same cycle as a timer pulse.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW = 8;
  localparam int ADDR_CTL  = 0;
  localparam int ADDR_PFLG = 1;
  localparam int ADDR_PEN  = 2;
  localparam int ADDR_PORT = 3;
  localparam int ADDR_CFG  = 4;
  localparam int NCORE     = 3;
  localparam int NPERI     = 2;
  localparam int BIT_EN0   = 3;
  localparam int BIT_PEN   = 6;
  localparam int BIT_GIE   = 7;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/intc_edge.sv
module intc_edge (
  input  logic clk,
  input  logic rst,
  input  logic d,
  input  logic rise_sel,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= d;
  end

  assign evt = rise_sel ? (d & ~prev) : (~d & prev);
endmodule

// File: rtl/intc_portchg.sv
module intc_portchg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic         capture,
  output logic         evt
);
  logic [W-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst)          snap <= '0;
    else if (capture) snap <= d;
  end

  assign evt = (d != snap);
endmodule

// File: rtl/intc_dispatch.sv
module intc_dispatch (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic irq_ack,
  input  logic ret_fie,
  input  logic gie_wr,
  input  logic gie_wval,
  input  logic sleep_mode,
  output logic gie,
  output logic irq_req,
  output logic nop_slot,
  output logic vec_load,
  output logic wake
);
  logic take, gie_drop;

  assign take     = irq_req & irq_ack;
  assign gie_drop = gie_wr & ~gie_wval;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      irq_req  <= 1'b0;
      nop_slot <= 1'b0;
      vec_load <= 1'b0;
      wake     <= 1'b0;
    end else begin
      if (take)         gie <= 1'b0;
      else if (ret_fie) gie <= 1'b1;
      else if (gie_wr)  gie <= gie_wval;
      irq_req  <= gie & pend & ~take & ~gie_drop;
      nop_slot <= gie & pend & ~take & gie_drop;
      vec_load <= take;
      wake     <= sleep_mode & pend;
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int          ADDR_W      = 3,
  parameter int          PORT_W      = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int          PC_W        = 13,
  parameter logic [12:0] VECTOR      = 13'h0004,
  parameter bit          PAR_PORT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              cmp_evt,
  input  logic              pp_evt,
  input  logic              sleep_mode,
  input  logic              irq_ack,
  input  logic              ret_fie,
  output logic              irq_req,
  output logic              nop_slot,
  output logic              vec_load,
  output logic [PC_W-1:0]   vec_addr,
  output logic              wake
);
  import intc_pkg::*;

  localparam logic [NPERI-1:0] PMASK = PAR_PORT_EN ? 2'b11 : 2'b01;

  logic [NCORE-1:0] cflag_q, cen_q;
  logic [NPERI-1:0] pflag_q, pen_q;
  logic             peri_en_q, rise_q, gie_q;
  logic             ext_s, ext_evt, port_evt, pp_set;
  logic [PORT_W-1:0] port_s;
  logic             sel_ctl, sel_pflg, sel_pen, sel_port, sel_cfg;
  logic             pend;
  logic [NCORE-1:0] core_set;
  logic [NPERI-1:0] peri_set;

  assign sel_ctl  = (bus_addr == ADDR_W'(ADDR_CTL));
  assign sel_pflg = (bus_addr == ADDR_W'(ADDR_PFLG));
  assign sel_pen  = (bus_addr == ADDR_W'(ADDR_PEN));
  assign sel_port = (bus_addr == ADDR_W'(ADDR_PORT));
  assign sel_cfg  = (bus_addr == ADDR_W'(ADDR_CFG));

  intc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s));

  intc_edge u_ext_edge (
    .clk(clk), .rst(rst), .d(ext_s), .rise_sel(rise_q), .evt(ext_evt));

  intc_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst(rst), .d(port_pins), .q(port_s));

  intc_portchg #(.W(PORT_W)) u_portchg (
    .clk(clk), .rst(rst), .d(port_s), .capture(bus_rd & sel_port),
    .evt(port_evt));

  generate
    if (PAR_PORT_EN) begin : g_pp
      assign pp_set = pp_evt;
    end else begin : g_no_pp
      assign pp_set = 1'b0;
    end
  endgenerate

  assign core_set = {port_evt, tmr_ovf, ext_evt};
  assign peri_set = {pp_set, cmp_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      cflag_q   <= '0;
      cen_q     <= '0;
      peri_en_q <= 1'b0;
      pflag_q   <= '0;
      pen_q     <= '0;
      rise_q    <= 1'b1;
    end else begin
      cflag_q <= ((bus_wr && sel_ctl) ? bus_wdata[NCORE-1:0] : cflag_q) | core_set;
      pflag_q <= (((bus_wr && sel_pflg) ? bus_wdata[NPERI-1:0] : pflag_q) | peri_set) & PMASK;
      if (bus_wr && sel_ctl) begin
        cen_q     <= bus_wdata[BIT_EN0 +: NCORE];
        peri_en_q <= bus_wdata[BIT_PEN];
      end
      if (bus_wr && sel_pen) pen_q  <= bus_wdata[NPERI-1:0] & PMASK;
      if (bus_wr && sel_cfg) rise_q <= bus_wdata[0];
    end
  end

  assign pend = (|(cflag_q & cen_q)) | (peri_en_q & (|(pflag_q & pen_q)));

  intc_dispatch u_disp (
    .clk(clk), .rst(rst), .pend(pend), .irq_ack(irq_ack), .ret_fie(ret_fie),
    .gie_wr(bus_wr & sel_ctl), .gie_wval(bus_wdata[BIT_GIE]),
    .sleep_mode(sleep_mode), .gie(gie_q), .irq_req(irq_req),
    .nop_slot(nop_slot), .vec_load(vec_load), .wake(wake));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_ctl)  bus_rdata <= {gie_q, peri_en_q, cen_q, cflag_q};
      if (sel_pflg) bus_rdata <= {{(DW-NPERI){1'b0}}, pflag_q};
      if (sel_pen)  bus_rdata <= {{(DW-NPERI){1'b0}}, pen_q};
      if (sel_port) bus_rdata <= {{(DW-PORT_W){1'b0}}, port_s};
      if (sel_cfg)  bus_rdata <= {{(DW-1){1'b0}}, rise_q};
    end
  end

  assign vec_addr = VECTOR[PC_W-1:0];
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_req,
  input logic       irq_ack,
  input logic       ret_fie,
  input logic       vec_load,
  input logic       nop_slot,
  input logic       wake,
  input logic       sleep_mode,
  input logic       gie,
  input logic       bus_wr,
  input logic       sel_ctl,
  input logic [2:0] cflag
);
  // R6
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> (!irq_req && vec_load && !gie));

  // R5
  no_req_without_gie_chk: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_req);

  // R8
  nop_excludes_req_chk: assert property (@(posedge clk) disable iff (rst)
    nop_slot |-> !irq_req);

  // R4
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cflag[1]) |-> $past(bus_wr && sel_ctl));

  // R9
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(sleep_mode));

  // R7
  ret_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_fie && !(irq_req && irq_ack)) |=> gie);
endmodule

bind intc_core intc_core_chk u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
  .ret_fie(ret_fie), .vec_load(vec_load), .nop_slot(nop_slot), .wake(wake),
  .sleep_mode(sleep_mode), .gie(gie_q), .bus_wr(bus_wr), .sel_ctl(sel_ctl),
  .cflag(cflag_q));

// File: tb/intc_core_tb.sv
module intc_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0, tmr_ovf = 1'b0, cmp_evt = 1'b0, pp_evt = 1'b0;
  logic [3:0] port_pins = '0;
  logic       sleep_mode = 1'b0, irq_ack = 1'b0, ret_fie = 1'b0;
  logic       irq_req, nop_slot, vec_load, wake;
  logic [12:0] vec_addr;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  intc_core u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_ovf(tmr_ovf), .port_pins(port_pins), .cmp_evt(cmp_evt), .pp_evt(pp_evt),
    .sleep_mode(sleep_mode), .irq_ack(irq_ack), .ret_fie(ret_fie),
    .irq_req(irq_req), .nop_slot(nop_slot), .vec_load(vec_load),
    .vec_addr(vec_addr), .wake(wake));

  // behavioural reference model
  bit       m_p1, m_p2, m_p3;
  bit [3:0] m_q1, m_q2, m_snap;
  bit [2:0] m_cf, m_ce;
  bit [1:0] m_pf, m_pe;
  bit       m_peri, m_gie, m_rise;
  bit       m_irq, m_nop, m_vec, m_wake;
  bit [7:0] m_rdata;

  always @(posedge clk) begin
    bit ev_ext, ev_port, pend, take, drop;
    bit [2:0] cf_n;
    bit [1:0] pf_n;
    if (rst) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_q1 = 0; m_q2 = 0; m_snap = 0;
      m_cf = 0; m_ce = 0; m_pf = 0; m_pe = 0; m_peri = 0; m_gie = 0; m_rise = 1;
      m_irq = 0; m_nop = 0; m_vec = 0; m_wake = 0; m_rdata = 0;
    end else begin
      ev_ext  = m_rise ? (m_p2 && !m_p3) : (!m_p2 && m_p3);
      ev_port = (m_q2 != m_snap);
      pend = ((m_cf & m_ce) != 0) || (m_peri && ((m_pf & m_pe) != 0));
      take = m_irq && irq_ack;
      drop = bus_wr && bus_addr == 0 && !bus_wdata[7];
      if (bus_rd) begin
        case (bus_addr)
          3'd0: m_rdata = {m_gie, m_peri, m_ce, m_cf};
          3'd1: m_rdata = {6'b0, m_pf};
          3'd2: m_rdata = {6'b0, m_pe};
          3'd3: m_rdata = {4'b0, m_q2};
          3'd4: m_rdata = {7'b0, m_rise};
          default: m_rdata = 8'h00;
        endcase
        if (bus_addr == 3) m_snap = m_q2;
      end
      cf_n = (bus_wr && bus_addr == 0) ? bus_wdata[2:0] : m_cf;
      if (ev_ext)  cf_n[0] = 1;
      if (tmr_ovf) cf_n[1] = 1;
      if (ev_port) cf_n[2] = 1;
      pf_n = (bus_wr && bus_addr == 1) ? bus_wdata[1:0] : m_pf;
      if (cmp_evt) pf_n[0] = 1;
      if (pp_evt)  pf_n[1] = 1;
      m_irq  = m_gie && pend && !take && !drop;
      m_nop  = m_gie && pend && !take && drop;
      m_vec  = take;
      m_wake = sleep_mode && pend;
      if (take)         m_gie = 0;
      else if (ret_fie) m_gie = 1;
      else if (bus_wr && bus_addr == 0) m_gie = bus_wdata[7];
      if (bus_wr && bus_addr == 0) begin m_ce = bus_wdata[5:3]; m_peri = bus_wdata[6]; end
      if (bus_wr && bus_addr == 2) m_pe = bus_wdata[1:0];
      if (bus_wr && bus_addr == 4) m_rise = bus_wdata[0];
      m_cf = cf_n; m_pf = pf_n;
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_pin;
      m_q2 = m_q1; m_q1 = port_pins;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 irq_req model", {15'b0, irq_req}, {15'b0, m_irq});
      chk("R8 nop_slot model", {15'b0, nop_slot}, {15'b0, m_nop});
      chk("R6 vec_load model", {15'b0, vec_load}, {15'b0, m_vec});
      chk("R9 wake model", {15'b0, wake}, {15'b0, m_wake});
      chk("R10 rdata model", {8'b0, bus_rdata}, {8'b0, m_rdata});
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, {8'b0, bus_rdata}, {8'b0, exp});
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); ret_fie = 1'b1;
    @(negedge clk); ret_fie = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 irq_req reset", {15'b0, irq_req}, 16'h0);
    chk("R1 wake reset", {15'b0, wake}, 16'h0);
    rd(3'd0, 8'h00, "R1 CTL reset");
    rd(3'd4, 8'h01, "R1 CFG reset");
    rd(3'd1, 8'h00, "R1 PFLG reset");

    // R2 rising edge, nothing enabled
    ext_pin = 1'b1;
    tick(5);
    rd(3'd0, 8'h01, "R2 ext flag rising");
    chk("R2 no irq while masked", {15'b0, irq_req}, 16'h0);

    // R5 enable ext and global
    wr(3'd0, 8'h89);
    tick(1);
    chk("R5 irq raised", {15'b0, irq_req}, 16'h1);

    // R6 acknowledge
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk("R6 vec_load", {15'b0, vec_load}, 16'h1);
    chk("R6 vec_addr", {3'b0, vec_addr}, 16'h0004);
    chk("R6 irq dropped", {15'b0, irq_req}, 16'h0);
    rd(3'd0, 8'h09, "R6 gie cleared");

    // R7 return with flag still set
    pulse_ret();
    tick(1);
    chk("R7 retaken", {15'b0, irq_req}, 16'h1);
    pulse_ack();
    wr(3'd0, 8'h08);
    pulse_ret();
    tick(2);
    chk("R7 no retake after clear", {15'b0, irq_req}, 16'h0);

    // R5 peripheral two-level mask
    wr(3'd2, 8'h01);
    @(negedge clk); cmp_evt = 1'b1;
    @(negedge clk); cmp_evt = 1'b0;
    rd(3'd1, 8'h01, "R2 cmp flag");
    tick(1);
    chk("R5 peri masked by PEN bit", {15'b0, irq_req}, 16'h0);
    wr(3'd0, 8'hC8);
    tick(1);
    chk("R5 peri request", {15'b0, irq_req}, 16'h1);

    // R8 clearing write suppresses dispatch
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h48; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    chk("R8 nop_slot", {15'b0, nop_slot}, 16'h1);
    chk("R8 irq suppressed", {15'b0, irq_req}, 16'h0);
    rd(3'd1, 8'h01, "R8 flag kept");

    // R9 wake with gie clear
    @(negedge clk); sleep_mode = 1'b1;
    tick(2);
    chk("R9 wake", {15'b0, wake}, 16'h1);
    sleep_mode = 1'b0;
    wr(3'd1, 8'h00);
    tick(2);
    chk("R9 wake low", {15'b0, wake}, 16'h0);

    // R4 hardware set beats clearing write
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h48; bus_wr = 1'b1; tmr_ovf = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd(3'd0, 8'h4A, "R4 hw set wins");
    wr(3'd0, 8'h48);
    rd(3'd0, 8'h48, "R4 software clear");

    // R3 port change
    rd(3'd3, 8'h00, "R3 port read");
    port_pins = 4'hA;
    tick(4);
    rd(3'd0, 8'h4C, "R3 change flag");
    rd(3'd3, 8'h0A, "R3 port value");
    wr(3'd0, 8'h48);
    tick(3);
    rd(3'd0, 8'h48, "R3 snapshot matches");

    // R2 falling edge select
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h00, "R10 CFG write");
    ext_pin = 1'b0;
    tick(5);
    rd(3'd0, 8'h49, "R2 ext flag falling");
    wr(3'd0, 8'h48);
    ext_pin = 1'b1;
    tick(5);
    rd(3'd0, 8'h48, "R2 rising ignored when falling selected");

    // R7 parallel-port source through the full path
    wr(3'd2, 8'h02);
    @(negedge clk); pp_evt = 1'b1;
    @(negedge clk); pp_evt = 1'b0;
    rd(3'd1, 8'h02, "R2 pp flag");
    pulse_ret();
    tick(1);
    chk("R7 pp request after return", {15'b0, irq_req}, 16'h1);
    pulse_ack();
    rd(3'd7, 8'h00, "R10 unused address");
    tick(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule